// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level shifting core of a serial peripheral port that always acts as bus master. It takes words from the head of a show-ahead transmit FIFO and shifts them out most significant bit first. At the same time it collects a word of the same width from the serial input and pushes each finished word into a receive FIFO. The serial clock comes from the system clock through two dividers in series. The first is an even prescaler that produces a tick. The second is a multiplier that counts those ticks, set by a rate field (SCR).

The configuration inputs are the clock idle level, the sampling phase, a two-bit frame-format selector, a data-size field holding the word width minus one, the prescale value, the rate field and an internal loopback switch. A frame-enable output is held low for every word in flight. When words are already waiting in the transmit FIFO, each one follows the last on the clock edge that ends it. A busy flag tells the surrounding logic when it is safe to change the configuration or drop chip select.

Top module: `spi_master_engine`

## Requirements
- R1: Every serial clock half period lasts (P/2)·(SCR+1) system clocks, P being the effective prescale. A frame of N bits keeps `frm_n` low for exactly 2·N half periods.
- R2: The effective prescale P is `cfg_presc` with bit 0 forced to zero. A result of 0 is used as 2.
- R3: The word width N is `cfg_dsize`+1 (7 gives 8 bits, 15 gives 16 bits). Field values 0, 1 and 2 give 4-bit words.
- R4: `sclk` idles at `cfg_cpol`. Data goes out MSB first. With `cfg_cpha`=0 the input is sampled on the first edge of each bit and the output changes on the second edge. With `cfg_cpha`=1 the output changes on the first edge and the input is sampled on the second. Modes 0 to 3 are polarity/phase 0/0, 0/1, 1/0 and 1/1.
- R5: `frm_n` is low while a word is shifted and high in idle. It rises on the same clock edge that ends the last word.
- R6: With `cfg_loop`=1 the transmitted bit stream is captured as input and `miso` has no effect on the received word.
- R7: Each completed word is presented on `rx_data` with a one-cycle `rx_push`. It is right-aligned, with zeros above bit N-1.
- R8: If the transmit FIFO is non-empty when a word ends, the next word is popped on that same edge. `frm_n` then stays low and the clock runs on without a gap.
- R9: While `en` is low, no word is popped. Dropping `en` during a word aborts it: `frm_n` is high after the next edge and no word is pushed.
- R10: `busy` is high while a word is in flight or the transmit FIFO is non-empty, and low otherwise.
- R11: A word starts only when `cfg_fmt` is 00. Any other value leaves pending words unpopped.
- R12: `tx_pop` pulses only when `tx_empty` is low. The word on `tx_data` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; low halts and aborts |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 first edge, 1 second edge |
| cfg_fmt | input | 2 | Frame format; only 00 transmits |
| cfg_dsize | input | SZW (4) | Word width minus one |
| cfg_presc | input | PW (8) | Even prescale, 2 to 254 |
| cfg_scr | input | SW (8) | Rate multiplier field, 0 to 255 |
| cfg_loop | input | 1 | Internal loopback of output into input |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DW (16) | Head word of transmit FIFO (right-aligned) |
| tx_pop | output | 1 | Pop strobe to transmit FIFO |
| rx_push | output | 1 | Push strobe to receive FIFO |
| rx_data | output | DW (16) | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frm_n | output | 1 | Frame enable, active low |
| busy | output | 1 | Word in flight or transmit data pending |

## Verification
A stuck or skewed edge counter changes the time `frm_n` stays low, so it shows up on the first word as a count other than 2·N·H. A wrong sampling edge or shift direction corrupts the received word or the bit pattern seen by the modelled slave on that same word, because the slave changes `miso` only on the opposite edge. An error in the pop/start gating shows up within one cycle as an extra or missing `tx_pop`, or as `frm_n` not rising after `en` falls. A divider that ignores bit 0 of the prescale, or clamps it wrongly, is caught by the frame length of the directed prescale cases.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Word width from the minus-one size field, clamped to [4, max_bits].
  function automatic int unsigned frame_bits(input int unsigned field,
                                             input int unsigned max_bits);
    if (field < 3) return 4;
    if (field + 1 > max_bits) return max_bits;
    return field + 1;
  endfunction

  // Half of the effective even prescale (bit 0 dropped, zero treated as 2).
  function automatic int unsigned half_prescale(input int unsigned raw);
    int unsigned even_v;
    even_v = raw & 32'hFFFF_FFFE;
    if (even_v == 0) return 1;
    return even_v / 2;
  endfunction

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_eng_pkg::*;
#(
  parameter int PW = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  input  logic [SW-1:0] scr,
  output logic          pre_tick,
  output logic          edge_stb
);
  localparam int HW = PW - 1;

  logic [HW-1:0] half_lim;
  logic [HW-1:0] pcnt;
  logic [SW-1:0] scnt;

  assign half_lim = HW'(half_prescale(32'(presc)) - 1);
  assign pre_tick = run && (pcnt == half_lim);
  assign edge_stb = pre_tick && (scnt == scr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (pre_tick) begin
      pcnt <= '0;
      scnt <= (scnt == scr) ? '0 : scnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SZW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           cfg_cpol,
  input  logic           cfg_cpha,
  input  logic [1:0]     cfg_fmt,
  input  logic [SZW-1:0] cfg_dsize,
  input  logic           cfg_loop,
  input  logic           tx_empty,
  input  logic [DW-1:0]  tx_data,
  input  logic           miso,
  input  logic           edge_stb,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_data,
  output logic           sclk,
  output logic           mosi,
  output logic           frm_n,
  output logic           active
);
  localparam int NBW = $clog2(DW) + 1;
  localparam int ECW = $clog2(2 * DW);

  logic [NBW-1:0] nbits;
  logic [ECW-1:0] edge_cnt;
  logic [DW-1:0]  tx_sh, rx_sh, aligned, rx_next, mask, done_word;
  logic           lead, trail, last_edge, frame_done, start_ok, load;
  logic           capture, launch, in_bit;

  assign nbits      = NBW'(frame_bits(32'(cfg_dsize), DW));
  assign last_edge  = (edge_cnt == ECW'(2 * int'(nbits) - 1));
  assign lead       = active && edge_stb && !edge_cnt[0];
  assign trail      = active && edge_stb &&  edge_cnt[0];
  assign frame_done = trail && last_edge;
  assign start_ok   = en && (cfg_fmt == 2'b00) && !tx_empty;
  assign load       = start_ok && (!active || frame_done);
  assign tx_pop     = load;

  assign capture = cfg_cpha ? trail : lead;
  assign launch  = cfg_cpha ? lead : (trail && !last_edge);
  assign in_bit  = cfg_loop ? mosi : miso;

  assign aligned   = tx_data << (DW - int'(nbits));
  assign rx_next   = {rx_sh[DW-2:0], in_bit};
  assign mask      = (DW'(1) << nbits) - DW'(1);
  assign done_word = (cfg_cpha ? rx_next : rx_sh) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      edge_cnt <= '0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      frm_n    <= 1'b1;
      rx_push  <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!en) begin
        active   <= 1'b0;
        frm_n    <= 1'b1;
        sclk     <= cfg_cpol;
        edge_cnt <= '0;
      end else begin
        if (capture) rx_sh <= rx_next;
        if (lead)  sclk <= ~cfg_cpol;
        if (trail) sclk <= cfg_cpol;
        if (launch) begin
          mosi  <= tx_sh[DW-1];
          tx_sh <= tx_sh << 1;
        end
        if (active && edge_stb) edge_cnt <= edge_cnt + 1'b1;
        if (frame_done) begin
          rx_push  <= 1'b1;
          rx_data  <= done_word;
          active   <= 1'b0;
          frm_n    <= 1'b1;
          edge_cnt <= '0;
        end
        if (load) begin
          active   <= 1'b1;
          frm_n    <= 1'b0;
          edge_cnt <= '0;
          mosi     <= aligned[DW-1];
          tx_sh    <= cfg_cpha ? aligned : (aligned << 1);
        end
        if (!active && !load) sclk <= cfg_cpol;
      end
    end
  end

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int DW  = 16,
  parameter int PW  = 8,
  parameter int SW  = 8,
  parameter int SZW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           cfg_cpol,
  input  logic           cfg_cpha,
  input  logic [1:0]     cfg_fmt,
  input  logic [SZW-1:0] cfg_dsize,
  input  logic [PW-1:0]  cfg_presc,
  input  logic [SW-1:0]  cfg_scr,
  input  logic           cfg_loop,
  input  logic           tx_empty,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_data,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic           frm_n,
  output logic           busy
);
  logic eng_active;
  logic eng_pre_tick;
  logic eng_edge_stb;

  spi_rate_div #(.PW(PW), .SW(SW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (eng_active),
    .presc    (cfg_presc),
    .scr      (cfg_scr),
    .pre_tick (eng_pre_tick),
    .edge_stb (eng_edge_stb)
  );

  spi_shift_core #(.DW(DW), .SZW(SZW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cfg_fmt   (cfg_fmt),
    .cfg_dsize (cfg_dsize),
    .cfg_loop  (cfg_loop),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .miso      (miso),
    .edge_stb  (eng_edge_stb),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .rx_data   (rx_data),
    .sclk      (sclk),
    .mosi      (mosi),
    .frm_n     (frm_n),
    .active    (eng_active)
  );

  assign busy = eng_active | ~tx_empty;

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cfg_cpol,
  input logic [1:0] cfg_fmt,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       sclk,
  input logic       frm_n,
  input logic       busy,
  input logic       edge_stb
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_no_pop_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_pop);

  assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> frm_n);

  assert_fmt_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt != 2'b00) |-> !tx_pop);

  assert_busy_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_n |-> busy);

  assert_push_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && frm_n && $past(frm_n) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  assert_edge_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> !frm_n);

endmodule

bind spi_master_engine spi_eng_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cfg_cpol (cfg_cpol),
  .cfg_fmt  (cfg_fmt),
  .tx_empty (tx_empty),
  .tx_pop   (tx_pop),
  .rx_push  (rx_push),
  .sclk     (sclk),
  .frm_n    (frm_n),
  .busy     (busy),
  .edge_stb (eng_edge_stb)
);

// File: tb/sim_spi_master_engine.sv
module sim_spi_master_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loop = 1'b0;
  logic [1:0] cfg_fmt = 2'b00;
  logic [3:0] cfg_dsize = 4'd7;
  logic [7:0] cfg_presc = 8'd2, cfg_scr = 8'd0;
  logic tx_empty, tx_pop, rx_push, sclk, mosi, miso, frm_n, busy;
  logic [15:0] tx_data, rx_data;

  logic [15:0] fifo_q [0:7];
  int head = 0, tail = 0;
  int checks = 0, fails = 0;

  // slave model state
  logic [15:0] slv_word = 16'h0, slv_rx = 16'h0;
  logic slv_bit = 1'b0;
  int sptr = -1, cur_n = 8;
  bit cur_pol = 0, cur_pha = 0, in_frame = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tx_empty = (head == tail);
  assign tx_data  = fifo_q[head & 7];
  assign miso     = slv_bit;

  always @(posedge clk) if (rst_n && tx_pop) head <= head + 1;

  spi_master_engine u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_fmt(cfg_fmt), .cfg_dsize(cfg_dsize), .cfg_presc(cfg_presc), .cfg_scr(cfg_scr),
    .cfg_loop(cfg_loop), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .frm_n(frm_n), .busy(busy)
  );

  always @(negedge frm_n) begin
    in_frame = 1;
    slv_rx = 16'h0;
    sptr = cur_n - 1;
    if (!cur_pha) begin
      slv_bit = slv_word[sptr];
      sptr = sptr - 1;
    end
  end

  always @(sclk) begin
    if (rst_n && in_frame && !$isunknown(sclk)) begin
      bit lead_e, samp;
      lead_e = (sclk != cur_pol);
      samp = cur_pha ? !lead_e : lead_e;
      if (samp) slv_rx = {slv_rx[14:0], mosi};
      else if (sptr >= 0) begin
        slv_bit = slv_word[sptr];
        sptr = sptr - 1;
      end
    end
  end

  function automatic int exp_bits(input int field);
    return (field <= 2) ? 4 : field + 1;
  endfunction

  function automatic int exp_half(input int pr, input int sc);
    int p;
    p = pr - (pr % 2);
    if (p == 0) p = 2;
    return (p / 2) * (sc + 1);
  endfunction

  function automatic logic [15:0] low_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    fifo_q[tail & 7] = w;
    tail = tail + 1;
  endtask

  task automatic wait_push(output bit got, output int low_cnt);
    int t;
    got = 0; low_cnt = 0; t = 0;
    while (!got && t < 20000) begin
      @(negedge clk);
      t++;
      if (rx_push) got = 1;
      else if (!frm_n) low_cnt++;
    end
  endtask

  task automatic do_word(input bit pol, input bit pha, input int ds, input int pr,
                         input int sc, input bit lb, input logic [15:0] tw,
                         input logic [15:0] sw);
    int n, h, cnt;
    bit got;
    logic [15:0] m, expv;
    in_frame = 0;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_dsize = 4'(ds);
    cfg_presc = 8'(pr); cfg_scr = 8'(sc); cfg_loop = lb;
    cur_pol = pol; cur_pha = pha;
    n = exp_bits(ds); cur_n = n; h = exp_half(pr, sc); m = low_mask(n);
    slv_word = sw;
    repeat (3) @(negedge clk);
    chk(sclk == pol, "R4 idle clock level", int'(sclk), int'(pol));
    push(tw);
    wait_push(got, cnt);
    chk(got, "R7 word pushed", int'(got), 1);
    expv = (lb ? tw : sw) & m;
    if (lb) chk(rx_data == expv, "R6 loopback word, miso ignored", int'(rx_data), int'(expv));
    else    chk(rx_data == expv, "R4 sample edge / R7 aligned word", int'(rx_data), int'(expv));
    chk((slv_rx & m) == (tw & m), "R4 MSB-first output stream", int'(slv_rx & m), int'(tw & m));
    chk(cnt == 2 * n * h, "R1 R2 R3 frame length", cnt, 2 * n * h);
    chk(frm_n == 1'b1, "R5 frame enable released", int'(frm_n), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int cnt, pops, highs, npush;
    logic [15:0] words [0:2];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_n == 1'b1, "R5 reset frame enable", int'(frm_n), 1);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(tx_pop == 1'b0 && rx_push == 1'b0, "R12 reset strobes", int'({tx_pop, rx_push}), 0);
    en = 1'b1;

    // all four modes, 8 and 16 bits, external slave
    do_word(0, 0, 7, 2, 0, 0, 16'h00A5, 16'h003C);
    do_word(0, 1, 7, 2, 1, 0, 16'h0096, 16'h00E1);
    do_word(1, 0, 15, 4, 0, 0, 16'hBEEF, 16'h1234);
    do_word(1, 1, 15, 2, 2, 0, 16'h8001, 16'h7FFE);
    // prescale corner cases (R2): odd, zero, one
    do_word(0, 0, 7, 5, 0, 0, 16'h005A, 16'h00C3);
    do_word(1, 0, 7, 0, 1, 0, 16'h0011, 16'h00EE);
    do_word(0, 1, 7, 1, 0, 0, 16'h0070, 16'h000F);
    // size clamp (R3): fields 1 and 3 give 4 bits
    do_word(0, 0, 1, 2, 0, 0, 16'hFFF9, 16'hFFF6);
    do_word(1, 1, 3, 2, 0, 0, 16'h000C, 16'h0003);
    // loopback ignores miso (R6)
    do_word(1, 0, 11, 2, 0, 1, 16'h0ABC, 16'h0543);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] tw;
      tw = 16'($urandom);
      do_word(1'($urandom), 1'($urandom), int'($urandom % 16), int'($urandom % 10),
              int'($urandom % 4), 1'($urandom), tw, (i % 2 == 0) ? ~tw : 16'($urandom));
    end

    // back-to-back words (R8)
    in_frame = 0;
    @(negedge clk);
    cfg_cpol = 0; cfg_cpha = 1; cfg_dsize = 4'd7; cfg_presc = 8'd2; cfg_scr = 8'd0; cfg_loop = 1;
    @(negedge clk);
    push(16'h0011); push(16'h0022); push(16'h0033);
    npush = 0; highs = 0; cnt = 0;
    for (int t = 0; t < 2000 && npush < 3; t++) begin
      @(negedge clk);
      if (rx_push) begin
        words[npush] = rx_data;
        npush++;
      end else if (cnt > 0 && frm_n) highs++;
      if (!frm_n) cnt++;
    end
    chk(npush == 3, "R8 three words pushed", npush, 3);
    chk(highs == 0, "R8 no gap between words", highs, 0);
    chk(cnt == 48, "R8 continuous clock length", cnt, 48);
    chk(words[0] == 16'h0011 && words[1] == 16'h0022 && words[2] == 16'h0033,
        "R8 word order", int'(words[2]), 16'h0033);

    // disabled: no pop, busy from pending data (R9, R10)
    @(negedge clk);
    en = 1'b0;
    push(16'h005D);
    pops = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (tx_pop) pops++;
    end
    chk(pops == 0, "R9 no pop while disabled", pops, 0);
    chk(busy == 1'b1, "R10 busy with pending word", int'(busy), 1);
    chk(frm_n == 1'b1, "R9 idle while disabled", int'(frm_n), 1);
    en = 1'b1;
    wait_push(got, cnt);
    chk(got && rx_data == 16'h005D, "R9 word sent after enable", int'(rx_data), 16'h005D);

    // non-SPI format: no start (R11)
    @(negedge clk);
    cfg_fmt = 2'b10;
    push(16'h00C6);
    pops = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (tx_pop) pops++;
    end
    chk(pops == 0 && frm_n, "R11 non-SPI format holds data", pops, 0);
    cfg_fmt = 2'b00;
    wait_push(got, cnt);
    chk(got && rx_data == 16'h00C6, "R11 word sent after format 00", int'(rx_data), 16'h00C6);

    // abort by clearing enable (R9, R10)
    @(negedge clk);
    cfg_dsize = 4'd15; cfg_presc = 8'd8; cfg_scr = 8'd3;
    push(16'hA55A);
    for (int t = 0; t < 100 && frm_n; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(frm_n == 1'b1, "R9 abort releases frame enable", int'(frm_n), 1);
    chk(busy == 1'b0, "R10 busy low after abort", int'(busy), 0);
    npush = 0;
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      if (rx_push) npush++;
    end
    chk(npush == 0, "R9 aborted word not pushed", npush, 0);
    en = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule